// File: doc/BRIEF.md
# Flash Watermark Imprint Sequencer

This block burns a fixed bit pattern into a reserved flash segment as physical wear rather than as stored charge. It runs a stress loop a programmable number of times. Each pass erases the whole segment, which leaves every bit at 1, and then programs every word of the segment with its pattern word. Bits that are 0 in the pattern are charged and discharged on every pass and wear out. Bits that are 1 are never programmed and stay fresh. Repeated for tens of thousands of passes, this leaves a mark that a later erase or rewrite cannot remove. A typical pattern word is 0x5443, the ASCII code for "TC".

The pattern is held in a small internal word buffer that the host loads while the sequencer is at rest. Commands go to a generic flash controller over a valid/acknowledge handshake. In accelerated mode each erase is cut short after a programmable number of clocks by a stop command, which shortens the whole imprint by a large factor. A host abort ends the run cleanly once the command in flight is acknowledged.

The state machine has five states. IDLE is the rest state. ERASE issues the segment erase. HALT issues the stop command that ends an erase early. PROG programs the words one after another. DONE is reached when the target pass count is met. The transitions are:
- start: IDLE or DONE to ERASE, or to DONE when the target is zero.
- erase-ack: ERASE to PROG.
- erase-cut: ERASE to HALT, when the accelerated delay expires.
- halt-ack: HALT to PROG.
- word-ack: PROG to PROG.
- pass-end: PROG to ERASE.
- target-hit: PROG to DONE.
- abort: ERASE, HALT or PROG to IDLE, after an acknowledge.

Top module: `wm_imprint_seq`

## Requirements
- R1: After reset the block is at rest. busy, done and fl_cmd_valid are 0 and cycle_cnt is 0.
- R2: A start pulse while at rest begins a run. Each pass issues one erase (fl_cmd 2'b01, fl_addr 0) and then one program per word (fl_cmd 2'b10) in ascending word index, with fl_addr set to the index and fl_wdata set to that buffer word.
- R3: A command other than erase keeps fl_cmd_valid high with fl_cmd, fl_addr and fl_wdata unchanged until fl_ack is seen. The next command of the run is presented in the cycle after that acknowledge.
- R4: cycle_cnt rises by one when the last word of a pass is acknowledged. When it equals the target, done goes high and stays high, with no command issued, until the next start. cycle_cnt never exceeds the target.
- R5: A start with a target of 0 goes straight to done and issues no command.
- R6: In accelerated mode, an erase left unacknowledged is presented for exactly abort_delay cycles. After that the stop command (fl_cmd 2'b11) is presented until it is acknowledged, and programming then begins.
- R7: The stop command is never issued outside accelerated mode, or when the erase is acknowledged before the delay runs out. In those cases the sequencer waits for the erase acknowledge.
- R8: A host abort during a run lets the command in flight finish. After that acknowledge the block returns to rest with done at 0, issues no further command, and keeps cycle_cnt.
- R9: Buffer writes take effect only while the block is at rest (IDLE or DONE). Writes during a run are ignored.
- R10: The target, the mode select and abort_delay are captured at start. Changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (used only while at rest) |
| abort_req | input | 1 | Host request to stop the run |
| target_cycles | input | CNT_W | Number of stress passes |
| accel_en | input | 1 | Select accelerated (cut-short) erase |
| abort_delay | input | DLY_W | Erase duration in clocks in accelerated mode |
| buf_wr_en | input | 1 | Pattern buffer write strobe |
| buf_wr_addr | input | AW | Pattern buffer word index |
| buf_wr_data | input | DATA_W | Pattern word to store |
| fl_cmd_valid | output | 1 | Command presented to the flash controller |
| fl_cmd | output | 2 | 01 erase, 10 program, 11 stop erase |
| fl_addr | output | AW | Word index within the segment |
| fl_wdata | output | DATA_W | Program data |
| fl_ack | input | 1 | Controller reports the current command complete |
| busy | output | 1 | Run in progress |
| done | output | 1 | Target pass count reached |
| cycle_cnt | output | CNT_W | Completed stress passes |

## Verification
On every cycle the assertions check the following. No command is issued while the block is at rest. A pending program or stop command holds steady until acknowledged. The stop command appears only straight after an unacknowledged erase and only in accelerated mode. The pass counter moves only by single steps or a clear, and never passes the captured target. Only the bench scenarios can show the rest: the actual order of commands and their pattern data, the exact length of a cut-short erase, what an abort and mid-run buffer or configuration writes do, and the zero-target case.

// File: rtl/wm_imprint_pkg.sv
package wm_imprint_pkg;
    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_ERASE = 2'b01,
        FC_PROG  = 2'b10,
        FC_STOP  = 2'b11
    } fcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_HALT,
        ST_PROG,
        ST_DONE
    } seq_st_e;
endpackage

// File: rtl/wm_pattern_buf.sv
module wm_pattern_buf #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (wr_en && (32'(wr_addr) < WORDS)) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/wm_erase_timer.sv
module wm_erase_timer #(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DLY_W-1:0] limit,
    output logic             expire
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign expire = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/wm_cycle_ctr.sv
module wm_cycle_ctr #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/wm_imprint_seq.sv
module wm_imprint_seq
    import wm_imprint_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 17,
    parameter int DLY_W  = 12,
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort_req,
    input  logic [CNT_W-1:0]  target_cycles,
    input  logic              accel_en,
    input  logic [DLY_W-1:0]  abort_delay,
    input  logic              buf_wr_en,
    input  logic [AW-1:0]     buf_wr_addr,
    input  logic [DATA_W-1:0] buf_wr_data,
    output logic              fl_cmd_valid,
    output logic [1:0]        fl_cmd,
    output logic [AW-1:0]     fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ack,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cycle_cnt
);
    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    seq_st_e           state_q, state_d;
    logic [AW-1:0]     idx_q;
    logic [CNT_W-1:0]  tgt_q;
    logic              accel_q;
    logic [DLY_W-1:0]  dly_q;
    logic              abort_pend_q;
    logic [DATA_W-1:0] pat_word;
    logic              at_rest, launch, abort_now, last_word, pass_end, hit, tmr_expire;

    assign at_rest   = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign launch    = at_rest && start;
    assign abort_now = abort_pend_q || abort_req;
    assign last_word = (idx_q == LAST_IDX);
    assign pass_end  = (state_q == ST_PROG) && fl_ack && last_word;
    assign hit       = ((cycle_cnt + 1'b1) == tgt_q);

    wm_pattern_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .AW(AW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr_en && at_rest),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .rd_addr (idx_q),
        .rd_data (pat_word)
    );

    wm_erase_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_ERASE),
        .limit  (dly_q),
        .expire (tmr_expire)
    );

    wm_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .inc   (pass_end),
        .count (cycle_cnt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = (target_cycles == '0) ? ST_DONE : ST_ERASE;
            end
            ST_ERASE: begin
                if (fl_ack)                       state_d = abort_now ? ST_IDLE : ST_PROG;
                else if (accel_q && tmr_expire)   state_d = ST_HALT;
            end
            ST_HALT: begin
                if (fl_ack) state_d = abort_now ? ST_IDLE : ST_PROG;
            end
            ST_PROG: begin
                if (fl_ack) begin
                    if (last_word && hit) state_d = ST_DONE;
                    else if (abort_now)   state_d = ST_IDLE;
                    else if (last_word)   state_d = ST_ERASE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            idx_q        <= '0;
            tgt_q        <= '0;
            accel_q      <= 1'b0;
            dly_q        <= '0;
            abort_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_PROG)        idx_q <= '0;
            else if (fl_ack && !last_word) idx_q <= idx_q + 1'b1;
            if (launch) begin
                tgt_q   <= target_cycles;
                accel_q <= accel_en;
                dly_q   <= abort_delay;
            end
            abort_pend_q <= !at_rest && abort_now
                            && (state_d != ST_IDLE) && (state_d != ST_DONE);
        end
    end

    always_comb begin
        fl_cmd_valid = 1'b0;
        fl_cmd       = FC_NONE;
        fl_addr      = '0;
        fl_wdata     = '0;
        busy         = !at_rest;
        done         = (state_q == ST_DONE);
        unique case (state_q)
            ST_ERASE: begin
                fl_cmd_valid = 1'b1;
                fl_cmd       = FC_ERASE;
            end
            ST_HALT: begin
                fl_cmd_valid = 1'b1;
                fl_cmd       = FC_STOP;
            end
            ST_PROG: begin
                fl_cmd_valid = 1'b1;
                fl_cmd       = FC_PROG;
                fl_addr      = idx_q;
                fl_wdata     = pat_word;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wm_imprint_chk.sv
module wm_imprint_chk #(
    parameter int CNT_W  = 17,
    parameter int AW     = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fl_cmd_valid,
    input logic [1:0]        fl_cmd,
    input logic [AW-1:0]     fl_addr,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              fl_ack,
    input logic [CNT_W-1:0]  cycle_cnt,
    input logic [CNT_W-1:0]  tgt_q,
    input logic              accel_q
);
    p_rest_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_cmd_valid);

    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && !fl_ack && fl_cmd != 2'b01)
        |=> (fl_cmd_valid && $stable(fl_cmd) && $stable(fl_addr) && $stable(fl_wdata)));

    p_stop_after_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_cmd_valid && fl_cmd == 2'b11)
        |-> $past(fl_cmd_valid && fl_cmd == 2'b01 && !fl_ack));

    p_stop_needs_accel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && fl_cmd == 2'b11) |-> accel_q);

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cycle_cnt) |-> ((cycle_cnt == $past(cycle_cnt) + 1'b1) || (cycle_cnt == '0)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_cnt <= tgt_q);

    p_done_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycle_cnt == tgt_q && !fl_cmd_valid));
endmodule

bind wm_imprint_seq wm_imprint_chk #(.CNT_W(CNT_W), .AW(AW), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .fl_cmd_valid (fl_cmd_valid),
    .fl_cmd       (fl_cmd),
    .fl_addr      (fl_addr),
    .fl_wdata     (fl_wdata),
    .fl_ack       (fl_ack),
    .cycle_cnt    (cycle_cnt),
    .tgt_q        (tgt_q),
    .accel_q      (accel_q)
);

// File: tb/test_wm_imprint_seq.sv
module test_wm_imprint_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS  = 4;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 17;
    localparam int DLY_W  = 12;
    localparam int AW     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0, abort_req = 1'b0, accel_en = 1'b0;
    logic [CNT_W-1:0]  target_cycles = '0;
    logic [DLY_W-1:0]  abort_delay = '0;
    logic              buf_wr_en = 1'b0;
    logic [AW-1:0]     buf_wr_addr = '0;
    logic [DATA_W-1:0] buf_wr_data = '0;
    logic              fl_cmd_valid, busy, done;
    logic [1:0]        fl_cmd;
    logic [AW-1:0]     fl_addr;
    logic [DATA_W-1:0] fl_wdata;
    logic              fl_ack = 1'b0;
    logic [CNT_W-1:0]  cycle_cnt;

    int n_checks = 0, n_err = 0;

    // flash controller model state
    int erase_lat = 0, prog_lat = 0, stop_lat = 0;
    int wcnt = 0, erun = 0, erun_min = 9999, erun_max = 0;
    logic [1:0] pcmd = 2'b00;
    int log_n = 0;
    logic [1:0]        log_cmd  [256];
    logic [AW-1:0]     log_addr [256];
    logic [DATA_W-1:0] log_data [256];
    logic [DATA_W-1:0] pat [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    wm_imprint_seq #(.WORDS(WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) i_wm_imprint_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort_req(abort_req),
        .target_cycles(target_cycles), .accel_en(accel_en), .abort_delay(abort_delay),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_ack(fl_ack), .busy(busy), .done(done), .cycle_cnt(cycle_cnt)
    );

    always @(negedge clk) begin
        int lat;
        if (!fl_cmd_valid || fl_ack || fl_cmd != pcmd) wcnt = 0;
        else wcnt = wcnt + 1;
        pcmd = fl_cmd;
        if (fl_cmd_valid && fl_cmd == 2'b01) erun = erun + 1;
        if (fl_cmd_valid && fl_cmd == 2'b10) erun = 0;
        lat = (fl_cmd == 2'b01) ? erase_lat : (fl_cmd == 2'b10) ? prog_lat : stop_lat;
        fl_ack = fl_cmd_valid && (wcnt >= lat);
        if (fl_ack && log_n < 256) begin
            log_cmd[log_n]  = fl_cmd;
            log_addr[log_n] = fl_addr;
            log_data[log_n] = fl_wdata;
            log_n = log_n + 1;
            if (fl_cmd == 2'b11) begin
                if (erun < erun_min) erun_min = erun;
                if (erun > erun_max) erun_max = erun;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_word(input int i, input logic [DATA_W-1:0] d);
        @(negedge clk);
        buf_wr_en = 1'b1; buf_wr_addr = AW'(i); buf_wr_data = d;
        @(negedge clk);
        buf_wr_en = 1'b0;
        if (!busy) pat[i] = d;
    endtask

    task automatic kick(input int tgt, input logic acc, input int dly);
        @(negedge clk);
        log_n = 0; erun = 0; erun_min = 9999; erun_max = 0;
        target_cycles = CNT_W'(tgt); accel_en = acc; abort_delay = DLY_W'(dly);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !done; i++) @(negedge clk);
    endtask

    function automatic int count_cmd(input logic [1:0] c);
        int n = 0;
        for (int i = 0; i < log_n; i++) if (log_cmd[i] == c) n++;
        return n;
    endfunction

    // order check for runs where every pass is one erase-type entry then WORDS programs
    function automatic int order_errors(input int passes, input logic [1:0] first_cmd);
        int bad = 0;
        for (int p = 0; p < passes; p++) begin
            if (log_cmd[p*(WORDS+1)] != first_cmd) bad++;
            for (int k = 0; k < WORDS; k++) begin
                int e = p*(WORDS+1) + 1 + k;
                if (log_cmd[e] != 2'b10 || log_addr[e] != AW'(k) || log_data[e] != pat[k]) bad++;
            end
        end
        return bad;
    endfunction

    task automatic t_reset_state;
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 valid", int'(fl_cmd_valid), 0);
        chk("R1 cycle_cnt", int'(cycle_cnt), 0);
    endtask

    task automatic t_normal_run;
        erase_lat = 3; prog_lat = 1; stop_lat = 0;
        kick(3, 1'b0, 0);
        chk("R2 busy after start", int'(busy), 1);
        wait_done(500);
        chk("R4 done", int'(done), 1);
        chk("R4 cycle_cnt", int'(cycle_cnt), 3);
        chk("R2 entries", log_n, 3*(WORDS+1));
        chk("R2 order and data", order_errors(3, 2'b01), 0);
        chk("R7 no stop in normal mode", count_cmd(2'b11), 0);
        repeat (6) @(negedge clk);
        chk("R4 done held", int'(done), 1);
        chk("R4 no command in done", log_n, 3*(WORDS+1));
    endtask

    task automatic t_zero_target;
        kick(0, 1'b0, 0);
        @(negedge clk);
        chk("R5 done", int'(done), 1);
        chk("R5 no commands", log_n, 0);
        chk("R5 cycle_cnt", int'(cycle_cnt), 0);
    endtask

    task automatic t_accel_run;
        erase_lat = 100; prog_lat = 0; stop_lat = 2;
        kick(2, 1'b1, 4);
        wait_done(500);
        chk("R6 done", int'(done), 1);
        chk("R6 stops", count_cmd(2'b11), 2);
        chk("R6 erase never acked", count_cmd(2'b01), 0);
        chk("R6 order", order_errors(2, 2'b11), 0);
        chk("R6 erase length min", erun_min, 4);
        chk("R6 erase length max", erun_max, 4);
    endtask

    task automatic t_accel_early_ack;
        erase_lat = 2; prog_lat = 0; stop_lat = 0;
        kick(2, 1'b1, 20);
        wait_done(500);
        chk("R7 done", int'(done), 1);
        chk("R7 no stop when erase acked", count_cmd(2'b11), 0);
        chk("R7 erases", count_cmd(2'b01), 2);
    endtask

    task automatic t_abort;
        erase_lat = 3; prog_lat = 3; stop_lat = 0;
        kick(5, 1'b0, 0);
        while (log_n < 3) @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 busy low", int'(busy), 0);
        chk("R8 done low", int'(done), 0);
        chk("R8 in-flight finished", log_n, 4);
        chk("R8 cycle_cnt kept", int'(cycle_cnt), 0);
        repeat (20) @(negedge clk);
        chk("R8 no later commands", log_n, 4);
    endtask

    task automatic t_buffer_lock;
        logic [DATA_W-1:0] old0;
        int bad;
        old0 = pat[0];
        erase_lat = 1; prog_lat = 2; stop_lat = 0;
        kick(2, 1'b0, 0);
        load_word(0, 16'h0000);
        wait_done(500);
        bad = 0;
        for (int i = 0; i < log_n; i++)
            if (log_cmd[i] == 2'b10 && log_addr[i] == '0 && log_data[i] != old0) bad++;
        chk("R9 write during run ignored", bad, 0);
        load_word(0, 16'hA5A5);
        kick(1, 1'b0, 0);
        wait_done(500);
        chk("R9 write at rest used", int'(log_data[1]), 16'hA5A5);
    endtask

    task automatic t_latched_cfg;
        erase_lat = 5; prog_lat = 0; stop_lat = 0;
        kick(2, 1'b0, 1);
        target_cycles = 7; accel_en = 1'b1; abort_delay = 1;
        wait_done(500);
        chk("R10 target captured", int'(cycle_cnt), 2);
        chk("R10 mode captured", count_cmd(2'b11), 0);
        chk("R10 erases", count_cmd(2'b01), 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) pat[i] = '1;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        load_word(0, 16'h5443);
        load_word(1, 16'h0F0F);
        load_word(2, 16'hFFFF);
        load_word(3, 16'h1234);
        t_normal_run();
        t_zero_target();
        t_accel_run();
        t_accel_early_ack();
        t_abort();
        t_buffer_lock();
        t_latched_cfg();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule